// File: doc/BRIEF.md
# I2C Byte-Addressed Memory Slave

This block is the slave end of a two-wire serial bus for a 128K x 8 synchronous memory that sits outside it. It runs entirely on a fast system clock. SCL and SDA are resynchronised and majority-filtered, and START and STOP conditions and SCL edges are recovered from the filtered lines. SDA is driven through an open-drain enable. When the output is asserted the line is pulled low, and when it is released the line floats high.

A transaction opens with a slave byte. That byte carries the device type, two strap bits, a page bit and the direction bit. Writes load a 17-bit address latch and then store bytes one after another. Reads fetch bytes from the latch position, with the next byte prefetched during the acknowledge slot. The latch keeps its value between transactions, so a read with no address phase continues from where the last access stopped. A random read is formed from a write header followed by a repeated START. A write-protect pin makes the slave refuse data bytes.

Top module: `serial_mem_port`

## Requirements
- R1: The slave acknowledges a slave byte only when bits 7..4 equal 1010, bit 3 equals strap[1] and bit 2 equals strap[0]. Any other slave byte is not acknowledged, and the block then ignores the bus until the next START.
- R2: A master code of the form 0000_1xxx is never acknowledged.
- R3: A write slave byte has bit 0 = 0. It is followed by address bits 15..8 and then 7..0, and bit 1 of the slave byte becomes address bit 16. Every later byte is stored at the latched address and acknowledged.
- R4: The address latch advances by one after each data byte moved in either direction, with no burst limit. It wraps from 0x1FFFF to 0x00000.
- R5: A read slave byte (bit 0 = 1) starts at the current latched address, which persists across transactions. Bit 1 of a read slave byte has no effect.
- R6: A data byte is written to memory only after its 8th bit has been received. A STOP before that point leaves the memory and the address latch unchanged.
- R7: While wr_protect is high, data bytes are not acknowledged, not stored, and do not advance the address. Address bytes are still acknowledged.
- R8: A write header (slave byte and two address bytes) followed by a repeated START and a read slave byte reads from the new address and stores nothing.
- R9: Read data leaves MSB first. The slave sends another byte only after a master ACK. A master NACK, or a START in the 9th clock, ends the read with SDA released. The slave changes sda_oe only while SCL is low.
- R10: sda_oe is low during reset, and it is low again on the cycle after a STOP or START is detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the pad |
| sda_i | input | 1 | Serial data line as seen on the pad |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| strap | input | 2 | Device select straps, compared with slave byte bits 3..2 |
| wr_protect | input | 1 | 1 refuses all data writes |
| mem_we | output | 1 | One-cycle memory write strobe |
| mem_re | output | 1 | One-cycle memory read strobe; data expected one cycle later |
| mem_addr | output | 17 | Memory address for the strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid the cycle after mem_re |

## Verification
The hardest cases to reach from the ports are an aborted byte and a protected write. In both, the only visible effect is on state that nothing outputs directly: the memory contents and the address latch. The bench therefore follows every such event with a current-address read, so the data returned shows both where the latch stands and whether the location changed. Directed cases cover the wrap at 0x1FFFF, a STOP after four data bits, and a START in the 9th read clock. Seeded random bursts of writes, random reads and current reads are then mixed in, some of them with write protect set.

// File: rtl/smp_pkg.sv
package smp_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 2 * BYTE_W + 1;
  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [2:0] {
    S_IDLE, S_RX, S_DEC, S_ACK, S_TX, S_MACK, S_WTX
  } st_t;

  typedef enum logic [1:0] {K_DEV, K_AHI, K_ALO, K_DATA} kind_t;
endpackage

// File: rtl/line_filter.sv
module line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_TAPS   = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int HALF = FILT_TAPS / 2;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_TAPS-1:0]   taps_q;
  int                     ones;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      taps_q <= '1;
      dout   <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], din};
      taps_q <= {taps_q[FILT_TAPS-2:0], sync_q[SYNC_STAGES-1]};
      dout   <= (ones > HALF);
    end
  end

  always_comb begin
    ones = 0;
    for (int i = 0; i < FILT_TAPS; i++) ones = ones + int'(taps_q[i]);
  end
endmodule

// File: rtl/cond_detect.sv
module cond_detect (
  input  logic clk,
  input  logic rst,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  assign scl_rise = scl & ~scl_q;
  assign scl_fall = ~scl & scl_q;
  assign start_c  = scl & scl_q & sda_q & ~sda;
  assign stop_c   = scl & scl_q & ~sda_q & sda;
endmodule

// File: rtl/serial_mem_port.sv
module serial_mem_port
  import smp_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_TAPS   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [1:0]        strap,
  input  logic              wr_protect,
  output logic              mem_we,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic [BYTE_W-1:0] mem_rdata
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw, filt;
  logic scl_f, sda_f, rise, fall, start_c, stop_c;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < LINES; g++) begin : g_filt
    line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_TAPS(FILT_TAPS)) u_filt (
      .clk(clk), .rst(rst), .din(raw[g]), .dout(filt[g])
    );
  end

  assign scl_f = filt[1];
  assign sda_f = filt[0];

  cond_detect u_cond (
    .clk(clk), .rst(rst), .scl(scl_f), .sda(sda_f),
    .scl_rise(rise), .scl_fall(fall), .start_c(start_c), .stop_c(stop_c)
  );

  st_t               state;
  kind_t             kind;
  logic [3:0]        cnt;
  logic [BYTE_W-1:0] sh, hi, txbyte, txsh;
  logic              ack_q, rd_mode, page, rd_q;
  logic [ADDR_W-1:0] addr;
  logic [BYTE_W-1:0] byte_in;

  assign byte_in = {sh[BYTE_W-2:0], sda_f};

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE; kind <= K_DEV; cnt <= '0; sh <= '0; hi <= '0;
      txbyte <= '0; txsh <= '0; ack_q <= 1'b0; rd_mode <= 1'b0;
      page <= 1'b0; rd_q <= 1'b0; addr <= '0; sda_oe <= 1'b0;
      mem_we <= 1'b0; mem_re <= 1'b0; mem_addr <= '0; mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      mem_re <= 1'b0;
      rd_q   <= mem_re;
      if (rd_q) txbyte <= mem_rdata;
      if (start_c) begin
        state <= S_RX; kind <= K_DEV; cnt <= '0; sda_oe <= 1'b0;
      end else if (stop_c) begin
        state <= S_IDLE; sda_oe <= 1'b0;
      end else begin
        unique case (state)
          S_IDLE: ;
          S_RX: if (rise) begin
            sh  <= byte_in;
            cnt <= cnt + 4'd1;
            if (cnt == 4'd7) begin
              state <= S_DEC;
              unique case (kind)
                K_DEV: begin
                  ack_q <= (byte_in[7:4] == DEV_TYPE) && (byte_in[3:2] == strap);
                  rd_mode <= byte_in[0];
                  page <= byte_in[1];
                  kind <= K_AHI;
                  if ((byte_in[7:4] == DEV_TYPE) && (byte_in[3:2] == strap) && byte_in[0]) begin
                    mem_re <= 1'b1; mem_addr <= addr; addr <= addr + ADDR_W'(1);
                  end
                end
                K_AHI: begin ack_q <= 1'b1; hi <= byte_in; kind <= K_ALO; end
                K_ALO: begin ack_q <= 1'b1; addr <= {page, hi, byte_in}; kind <= K_DATA; end
                K_DATA: begin
                  ack_q <= ~wr_protect;
                  if (!wr_protect) begin
                    mem_we <= 1'b1; mem_addr <= addr; mem_wdata <= byte_in;
                    addr <= addr + ADDR_W'(1);
                  end
                end
              endcase
            end
          end
          S_DEC: if (fall) begin
            sda_oe <= ack_q;
            state  <= ack_q ? S_ACK : S_IDLE;
          end
          S_ACK, S_WTX: if (fall) begin
            cnt <= '0;
            if (rd_mode) begin
              sda_oe <= ~txbyte[BYTE_W-1];
              txsh   <= {txbyte[BYTE_W-2:0], 1'b0};
              state  <= S_TX;
            end else begin
              sda_oe <= 1'b0;
              state  <= S_RX;
            end
          end
          S_TX: begin
            if (rise) cnt <= cnt + 4'd1;
            if (fall) begin
              if (cnt == 4'd8) begin
                sda_oe <= 1'b0; state <= S_MACK;
              end else begin
                sda_oe <= ~txsh[BYTE_W-1];
                txsh   <= {txsh[BYTE_W-2:0], 1'b0};
              end
            end
          end
          S_MACK: if (rise) begin
            if (!sda_f) begin
              mem_re <= 1'b1; mem_addr <= addr; addr <= addr + ADDR_W'(1);
              state <= S_WTX;
            end else begin
              state <= S_IDLE;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  // R7
  wp_block_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !$past(wr_protect));
  // R6
  one_write_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);
  // R10
  stop_release_chk: assert property (@(posedge clk) disable iff (rst)
    stop_c |=> !sda_oe);
  // R10
  start_release_chk: assert property (@(posedge clk) disable iff (rst)
    start_c |=> !sda_oe);
  // R4
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && mem_re));
  // R9
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    (scl_f && !start_c && !stop_c && !$past(start_c) && !$past(stop_c)) |=> $stable(sda_oe));
endmodule

// File: tb/test_serial_mem_port.sv
module test_serial_mem_port;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 6;
  localparam int AMASK = 32'h1FFFF;

  logic clk = 1'b0, rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, mem_we, mem_re, wr_protect = 1'b0;
  logic [1:0] strap = 2'b10;
  logic [16:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata = 8'h00;
  logic line;

  int checks = 0, failures = 0, oe_viol = 0;
  bit done = 0;
  logic [7:0] mem_model [int];
  logic [7:0] exp_mem [int];
  int exp_addr = 0;
  logic scl_prev = 1'b1, oe_prev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign line = sda_m & ~sda_oe;

  serial_mem_port i_serial_mem_port (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(line), .sda_oe(sda_oe),
    .strap(strap), .wr_protect(wr_protect), .mem_we(mem_we), .mem_re(mem_re),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] init_val(int a);
    return a[7:0] ^ a[15:8] ^ {7'd0, a[16]} ^ 8'h3C;
  endfunction
  function automatic logic [7:0] exp_rd(int a);
    return exp_mem.exists(a) ? exp_mem[a] : init_val(a);
  endfunction

  always @(posedge clk) begin
    if (mem_we) mem_model[int'(mem_addr)] = mem_wdata;
    if (mem_re) mem_rdata <= mem_model.exists(int'(mem_addr)) ? mem_model[int'(mem_addr)]
                                                            : init_val(int'(mem_addr));
  end

  // R9 monitor: sda_oe must not move while SCL stays high
  always @(negedge clk) begin
    if (!rst && scl_m && scl_prev && sda_oe != oe_prev) oe_viol++;
    scl_prev <= scl_m;
    oe_prev  <= sda_oe;
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(int n); repeat (n) @(negedge clk); endtask

  task automatic i2c_start;
    sda_m = 1; hold(Q); scl_m = 1; hold(Q); sda_m = 0; hold(Q); scl_m = 0; hold(Q);
  endtask
  task automatic i2c_stop;
    sda_m = 0; hold(Q); scl_m = 1; hold(Q); sda_m = 1; hold(2*Q);
  endtask
  task automatic put_bit(bit b);
    sda_m = b; hold(Q); scl_m = 1; hold(2*Q); scl_m = 0; hold(Q);
  endtask
  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    sda_m = 1; hold(Q); scl_m = 1; hold(Q); ack = !line; hold(Q); scl_m = 0; hold(Q);
  endtask
  task automatic recv_byte(output logic [7:0] b, input bit mack);
    sda_m = 1;
    for (int i = 0; i < 8; i++) begin
      hold(Q); scl_m = 1; hold(Q); b = {b[6:0], line}; hold(Q); scl_m = 0; hold(Q);
    end
    sda_m = !mack; hold(Q); scl_m = 1; hold(2*Q); scl_m = 0; hold(Q); sda_m = 1;
  endtask

  function automatic logic [7:0] dev(bit page, bit rd);
    return {4'b1010, strap, page, rd};
  endfunction

  // header: slave write byte + two address bytes (R3)
  task automatic set_addr(int a);
    bit ack;
    i2c_start;
    send_byte(dev(a[16], 0), ack); chk(ack, "R3 dev ack", ack, 1);
    send_byte(a[15:8], ack);       chk(ack, "R7/R3 addr hi ack", ack, 1);
    send_byte(a[7:0], ack);        chk(ack, "R7/R3 addr lo ack", ack, 1);
    exp_addr = a & AMASK;
  endtask

  task automatic write_burst(int a, int n);
    bit ack;
    logic [7:0] d;
    set_addr(a);
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      send_byte(d, ack);
      chk(ack == !wr_protect, "R3/R7 data ack", ack, !wr_protect);
      if (!wr_protect) begin
        exp_mem[exp_addr] = d;
        exp_addr = (exp_addr + 1) & AMASK; // R4
      end
    end
    i2c_stop;
  endtask

  task automatic read_burst(int n, bit page, bit restart);
    bit ack;
    logic [7:0] d;
    i2c_start;
    send_byte(dev(page, 1), ack); chk(ack, "R5 read dev ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(d, i != n - 1);
      chk(d == exp_rd(exp_addr), "R9 read data", d, exp_rd(exp_addr));
      exp_addr = (exp_addr + 1) & AMASK;
    end
    if (!restart) i2c_stop;
  endtask

  initial begin
    bit ack;
    logic [7:0] d;
    void'($urandom(32'd4711));
    hold(5);
    // R10 reset state
    chk(sda_oe == 0 && mem_we == 0 && mem_re == 0, "R10 reset outputs", sda_oe, 0);
    rst = 0; hold(5);

    // R3 write then R8 random read
    write_burst(17'h01234, 3);
    set_addr(17'h01234);
    read_burst(3, 0, 0);
    // R5 current-address read continues after previous access
    write_burst(17'h00100, 4);
    set_addr(17'h00101); i2c_stop;
    read_burst(1, 1, 0);   // page bit ignored on read
    read_burst(2, 0, 0);

    // R1 strap mismatch, wrong type
    i2c_start; send_byte({4'b1010, ~strap, 2'b00}, ack); chk(!ack, "R1 strap mismatch nack", ack, 0); i2c_stop;
    i2c_start; send_byte(8'hB4, ack); chk(!ack, "R1 wrong type nack", ack, 0); i2c_stop;
    // R2 master code
    i2c_start; send_byte(8'h0D, ack); chk(!ack, "R2 master code nack", ack, 0); i2c_stop;
    read_burst(1, 0, 0);   // nothing changed by ignored bytes

    // R3 page bit sets address bit 16
    write_burst(17'h10055, 1);
    set_addr(17'h00055);
    read_burst(1, 0, 0);
    set_addr(17'h10055);
    read_burst(1, 0, 0);

    // R4 wrap
    write_burst(17'h1FFFF, 2);
    set_addr(17'h1FFFF);
    read_burst(2, 0, 0);
    chk(exp_addr == 1, "R4 wrap address", exp_addr, 1);

    // R7 write protect: data nacked, address unchanged
    set_addr(17'h00200); i2c_stop;
    wr_protect = 1;
    write_burst(17'h00200, 2);
    wr_protect = 0;
    read_burst(1, 0, 0);

    // R6 abort after 4 data bits
    set_addr(17'h00300);
    for (int i = 0; i < 4; i++) put_bit(1'b0);
    i2c_stop;
    read_burst(1, 0, 0);
    chk(exp_mem.exists(32'h300) == 0 && !mem_model.exists(32'h300), "R6 abort no store", 0, 0);

    // R9 START in 9th clock ends read, then new read continues
    set_addr(17'h00400);
    i2c_start; send_byte(dev(0, 1), ack);
    sda_m = 1;
    for (int i = 0; i < 8; i++) begin
      hold(Q); scl_m = 1; hold(Q); d = {d[6:0], line}; hold(Q); scl_m = 0; hold(Q);
    end
    chk(d == exp_rd(32'h400), "R9 byte before restart", d, exp_rd(32'h400));
    exp_addr = 32'h401;
    hold(2);
    chk(sda_oe == 0, "R9 released in 9th clock", sda_oe, 0);
    read_burst(2, 0, 0);

    // random mix
    for (int it = 0; it < 24; it++) begin
      int op = $urandom_range(0, 2);
      int a = $urandom & AMASK;
      int n = $urandom_range(1, 4);
      if (op == 0) begin
        wr_protect = ($urandom_range(0, 4) == 0);
        write_burst(a, n);
        wr_protect = 0;
      end else if (op == 1) begin
        set_addr(a); read_burst(n, 0, 0);
      end else begin
        read_burst(n, 0, 0);
      end
    end

    chk(oe_viol == 0, "R9 sda_oe stable while SCL high", oe_viol, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule